// File: doc/BRIEF.md
# Big-Window I/O Address Translator

The block converts a 32-bit processor physical address that lands in one of the large I/O windows into a 48-bit address for the I/O fabric and a 4-bit target widget number. A bank of seven software-written translation entries serves the windows numbered 1 to 7. Each entry holds a 5-bit upper-address offset, a 4-bit widget number and a single I/O-space flag. Window 0 has no entry, so an address that selects it is reported as a miss.

A mode input chooses between two node-addressing schemes. In mode M (`mode_n_i` = 0) the window number is address bits [31:29] and the low 29 bits pass straight through. In mode N (`mode_n_i` = 1) the window number is bits [30:28], the low 28 bits pass through, and the entry's I/O-space flag becomes output bit 47. The lookup is combinational. The result is captured in output registers on the edge where the request is valid, so the response appears one cycle after the request. Software writes entries through a small register port and can read them back through the same port.

Top module: `big_window_xlate`

## Requirements
- R1: While `rst_ni` is low, `rsp_valid_o`, `rsp_addr_o`, `rsp_widget_o` and `rsp_miss_o` are zero. After any reset, every entry reads back as zero.
- R2: A write stores only the offset in bits [4:0], the widget number in bits [11:8] and the I/O-space flag in bit 12. A read through `cfg_rdata_o` returns zero in all other bits, whatever was written there.
- R3: A write to index 0 changes no entry, and a read of index 0 returns zero.
- R4: `rsp_valid_o` equals the value `req_valid_i` had on the previous rising clock edge.
- R5: In mode M, address bits [31:29] select the entry. Output bits [33:0] are {offset, address[28:0]} and bits [47:34] are zero.
- R6: In mode M the I/O-space flag has no effect, so output bit 47 is zero even when the flag is set.
- R7: In mode N, address bits [30:28] select the entry and address bit 31 is not used. Output bits [32:0] are {offset, address[27:0]} and bits [46:33] are zero.
- R8: In mode N, output bit 47 equals the selected entry's I/O-space flag.
- R9: `rsp_widget_o` equals the widget field of the selected entry.
- R10: A window number of 0 sets `rsp_miss_o` and gives a zero address and a zero widget number. A nonzero window number clears `rsp_miss_o`, even when the selected entry holds all zeros.
- R11: While `req_valid_i` is low, `rsp_addr_o`, `rsp_widget_o` and `rsp_miss_o` keep their previous values.
- R12: A request on the same edge as an entry write uses the old contents of that entry. A request on any later edge uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_n_i | input | 1 | 0 = mode M, 1 = mode N |
| cfg_we_i | input | 1 | Entry write enable |
| cfg_idx_i | input | 3 | Entry index for both write and read; valid entries are 1 to 7 |
| cfg_wdata_i | input | 64 | Entry write data |
| cfg_rdata_o | output | 64 | Contents of the entry at `cfg_idx_i`, combinational |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Processor physical address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_addr_o | output | 48 | Translated fabric address |
| rsp_widget_o | output | 4 | Target widget number |
| rsp_miss_o | output | 1 | Address selected window 0 |

## Verification
Each entry reaches the ports in two ways: directly through `cfg_rdata_o` in the same cycle, and as offset, widget and bit-47 fields in the response one cycle after a request. A corrupted entry, or a wrong window decode, therefore shows up on the first read or request that touches that entry. A select taken from the wrong bit slice shows on the first vector whose bit 31 and bit 28 differ. Wrongly latched reserved bits show at once in a read-back. A stale entry is caught by the request issued on the same edge as a rewrite and by the request issued on the edge after it.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  localparam int ADDR_W   = 32;
  localparam int XADDR_W  = 48;
  localparam int REG_W    = 64;
  localparam int OFF_W    = 5;
  localparam int WID_W    = 4;
  localparam int SEL_W    = 3;
  localparam int N_ENTRY  = (1 << SEL_W) - 1;  // window 0 has no entry
  // register field positions
  localparam int OFF_LSB  = 0;
  localparam int WID_LSB  = 8;
  localparam int IOSP_BIT = 12;

  typedef struct packed {
    logic             iosp;
    logic [WID_W-1:0] widget;
    logic [OFF_W-1:0] offset;
  } entry_t;
endpackage

// File: rtl/bwt_entry_bank.sv
module bwt_entry_bank
  import bwt_pkg::*;
#(
  parameter int N_ENT  = N_ENTRY,
  parameter int IDX_W  = SEL_W,
  parameter int DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  lk_sel_i,
  output entry_t            lk_entry_o,
  output logic              lk_hit_o
);
  entry_t wr_entry;
  entry_t ent_w [N_ENT];
  logic   unused_rsvd;

  assign wr_entry.iosp   = wr_data_i[IOSP_BIT];
  assign wr_entry.widget = wr_data_i[WID_LSB +: WID_W];
  assign wr_entry.offset = wr_data_i[OFF_LSB +: OFF_W];
  // reserved bits are dropped on write
  assign unused_rsvd = ^{wr_data_i[DATA_W-1:IOSP_BIT+1],
                         wr_data_i[WID_LSB-1:OFF_LSB+OFF_W]};

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    entry_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g + 1))) q <= wr_entry;
    end
    assign ent_w[g] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_ENT; k++) begin
      if (rd_idx_i == IDX_W'(k + 1)) begin
        rd_data_o[OFF_LSB +: OFF_W] = ent_w[k].offset;
        rd_data_o[WID_LSB +: WID_W] = ent_w[k].widget;
        rd_data_o[IOSP_BIT]         = ent_w[k].iosp;
      end
    end
  end

  always_comb begin
    lk_entry_o = '0;
    lk_hit_o   = 1'b0;
    for (int k = 0; k < N_ENT; k++) begin
      if (lk_sel_i == IDX_W'(k + 1)) begin
        lk_entry_o = ent_w[k];
        lk_hit_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwt_xlate.sv
module bwt_xlate
  import bwt_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int XW  = XADDR_W,
  parameter int SW  = SEL_W
) (
  input  logic             mode_n_i,
  input  logic [AW-1:0]    addr_i,
  output logic [SW-1:0]    sel_o,
  input  entry_t           ent_i,
  input  logic             hit_i,
  output logic [XW-1:0]    xaddr_o,
  output logic [WID_W-1:0] widget_o,
  output logic             miss_o
);
  localparam int PASS_M   = AW - SW;     // pass-through width, mode M
  localparam int PASS_N   = PASS_M - 1;  // one bit less in mode N
  localparam int IOSP_OUT = XW - 1;

  assign sel_o = mode_n_i ? addr_i[AW-2 -: SW] : addr_i[AW-1 -: SW];

  always_comb begin
    xaddr_o  = '0;
    widget_o = '0;
    miss_o   = !hit_i;
    if (hit_i) begin
      widget_o = ent_i.widget;
      if (mode_n_i) begin
        xaddr_o[PASS_N+OFF_W-1:0] = {ent_i.offset, addr_i[PASS_N-1:0]};
        xaddr_o[IOSP_OUT]         = ent_i.iosp;
      end else begin
        xaddr_o[PASS_M+OFF_W-1:0] = {ent_i.offset, addr_i[PASS_M-1:0]};
      end
    end
  end
endmodule

// File: rtl/big_window_xlate.sv
module big_window_xlate
  import bwt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_n_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_idx_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  output logic [REG_W-1:0]   cfg_rdata_o,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               rsp_valid_o,
  output logic [XADDR_W-1:0] rsp_addr_o,
  output logic [WID_W-1:0]   rsp_widget_o,
  output logic               rsp_miss_o
);
  logic [SEL_W-1:0]   sel;
  entry_t             ent;
  logic               hit;
  logic [XADDR_W-1:0] xaddr_d;
  logic [WID_W-1:0]   widget_d;
  logic               miss_d;

  bwt_entry_bank #(.N_ENT(N_ENTRY), .IDX_W(SEL_W), .DATA_W(REG_W)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_data_i  (cfg_wdata_i),
    .rd_idx_i   (cfg_idx_i),
    .rd_data_o  (cfg_rdata_o),
    .lk_sel_i   (sel),
    .lk_entry_o (ent),
    .lk_hit_o   (hit)
  );

  bwt_xlate #(.AW(ADDR_W), .XW(XADDR_W), .SW(SEL_W)) i_xlate (
    .mode_n_i (mode_n_i),
    .addr_i   (req_addr_i),
    .sel_o    (sel),
    .ent_i    (ent),
    .hit_i    (hit),
    .xaddr_o  (xaddr_d),
    .widget_o (widget_d),
    .miss_o   (miss_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_widget_o <= '0;
      rsp_miss_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o   <= xaddr_d;
        rsp_widget_o <= widget_d;
        rsp_miss_o   <= miss_d;
      end
    end
  end
endmodule

// File: rtl/bwt_checker.sv
module bwt_checker
  import bwt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_n_i,
  input logic [REG_W-1:0]   cfg_rdata_o,
  input logic               req_valid_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               rsp_valid_o,
  input logic [XADDR_W-1:0] rsp_addr_o,
  input logic [WID_W-1:0]   rsp_widget_o,
  input logic               rsp_miss_o
);
  localparam int PASS_M = ADDR_W - SEL_W;
  localparam int PASS_N = PASS_M - 1;
  localparam logic [REG_W-1:0] KEEP =
    (REG_W'(1) << IOSP_BIT) | (REG_W'((1 << WID_W) - 1) << WID_LSB) |
    (REG_W'((1 << OFF_W) - 1) << OFF_LSB);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rsp_valid_o == $past(req_valid_i)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~KEEP) == '0); // R2

  AST_M_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !mode_n_i && (req_addr_i[ADDR_W-1 -: SEL_W] != '0)
    |=> rsp_addr_o[PASS_M-1:0] == $past(req_addr_i[PASS_M-1:0])); // R5

  AST_M_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !mode_n_i |=> rsp_addr_o[XADDR_W-1:PASS_M+OFF_W] == '0); // R6

  AST_N_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_n_i && (req_addr_i[ADDR_W-2 -: SEL_W] != '0)
    |=> rsp_addr_o[PASS_N-1:0] == $past(req_addr_i[PASS_N-1:0])); // R7

  AST_N_MID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_n_i |=> rsp_addr_o[XADDR_W-2:PASS_N+OFF_W] == '0); // R7

  AST_MISS_ON_W0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ((mode_n_i ? req_addr_i[ADDR_W-2 -: SEL_W]
                              : req_addr_i[ADDR_W-1 -: SEL_W]) == '0)
    |=> rsp_miss_o); // R10

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_addr_o == '0) && (rsp_widget_o == '0)); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(rsp_addr_o) && $stable(rsp_widget_o) &&
                     $stable(rsp_miss_o)); // R11
endmodule

bind big_window_xlate bwt_checker i_bwt_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_n_i     (mode_n_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_addr_o   (rsp_addr_o),
  .rsp_widget_o (rsp_widget_o),
  .rsp_miss_o   (rsp_miss_o)
);

// File: tb/test_big_window_xlate.sv
`timescale 1ns/1ps
module test_big_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [47:0] rsp_addr;
  logic [3:0]  rsp_widget;
  logic        rsp_miss;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  big_window_xlate i_big_window_xlate (
    .clk_i(clk), .rst_ni(rst_n), .mode_n_i(mode_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_widget_o(rsp_widget),
    .rsp_miss_o(rsp_miss)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] addr;
    logic [47:0] xaddr;
    logic [3:0]  wid;
    logic        miss;
  } vec_t;

  // entries: {iosp, widget, offset}
  localparam logic [9:0] ENT [1:7] = '{
    {1'b1, 4'h8, 5'h01}, {1'b0, 4'h9, 5'h02}, {1'b1, 4'hA, 5'h1F},
    {1'b0, 4'hB, 5'h10}, {1'b1, 4'hC, 5'h05}, {1'b0, 4'hD, 5'h06},
    {1'b1, 4'hF, 5'h15}};

  localparam vec_t VECS [12] = '{
    '{1'b0, 32'h3234_5678, 48'h0000_3234_5678, 4'h8, 1'b0},  // R5 R6
    '{1'b0, 32'hFFFF_FFFF, 48'h0002_BFFF_FFFF, 4'hF, 1'b0},  // R5 R6
    '{1'b0, 32'h1ABC_DEF0, 48'h0000_0000_0000, 4'h0, 1'b1},  // R10
    '{1'b0, 32'h6000_0001, 48'h0003_E000_0001, 4'hA, 1'b0},  // R5
    '{1'b1, 32'h1234_5678, 48'h8000_1234_5678, 4'h8, 1'b0},  // R7 R8
    '{1'b1, 32'hF0FF_FFFF, 48'h8001_50FF_FFFF, 4'hF, 1'b0},  // R7 R8
    '{1'b1, 32'h8765_4321, 48'h0000_0000_0000, 4'h0, 1'b1},  // R10, bit 31 unused
    '{1'b1, 32'h4ABC_DEF0, 48'h0001_0ABC_DEF0, 4'hB, 1'b0},  // R7 R8
    '{1'b1, 32'h2000_0000, 48'h0000_2000_0000, 4'h9, 1'b0},  // R7
    '{1'b0, 32'hA000_0000, 48'h0000_A000_0000, 4'hC, 1'b0},  // R6
    '{1'b1, 32'hD000_0003, 48'h8000_5000_0003, 4'hC, 1'b0},  // R8
    '{1'b0, 32'hC000_0000, 48'h0000_C000_0000, 4'hD, 1'b0}}; // R9

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [63:0] reg_of(input logic [9:0] e);
    return {51'd0, e[9], e[8:5], 3'd0, e[4:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", 64'(rsp_valid), 64'd0);
    chk("R1 addr", 64'(rsp_addr), 64'd0);
    chk("R1 widget/miss", 64'({rsp_widget, rsp_miss}), 64'd0);
    for (int k = 1; k <= 7; k++) begin
      cfg_idx = 3'(k); #1;
      chk("R1 entry", cfg_rdata, 64'd0);
    end
    rst_n = 1'b1;

    // program with reserved bits set
    for (int k = 1; k <= 7; k++)
      wr(3'(k), 64'hFFFF_FFFF_FFFF_E0E0 | reg_of(ENT[k]));
    for (int k = 1; k <= 7; k++) begin
      cfg_idx = 3'(k); #1;
      chk("R2 readback", cfg_rdata, reg_of(ENT[k]));
    end

    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_idx = 3'd0; #1;
    chk("R3 idx0 read", cfg_rdata, 64'd0);
    for (int k = 1; k <= 7; k++) begin
      cfg_idx = 3'(k); #1;
      chk("R3 unchanged", cfg_rdata, reg_of(ENT[k]));
    end

    @(negedge clk);
    for (int v = 0; v < 12; v++) begin
      req_valid = 1'b1; mode_n = VECS[v].mode; req_addr = VECS[v].addr;
      @(negedge clk);
      chk("R4 valid", 64'(rsp_valid), 64'd1);
      chk("R5/R6/R7/R8 addr", 64'(rsp_addr), 64'(VECS[v].xaddr));
      chk("R9 widget", 64'(rsp_widget), 64'(VECS[v].wid));
      chk("R10 miss", 64'(rsp_miss), 64'(VECS[v].miss));
    end

    // R11: idle request leaves outputs alone
    req_valid = 1'b0; mode_n = 1'b1; req_addr = 32'h2000_0000;
    @(negedge clk);
    chk("R4 valid low", 64'(rsp_valid), 64'd0);
    chk("R11 hold addr", 64'(rsp_addr), 64'h0000_C000_0000);
    chk("R11 hold widget", 64'(rsp_widget), 64'hD);

    // R12: same-edge write sees old entry, next edge sees new
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wdata = {51'd0, 1'b0, 4'h1, 3'd0, 5'h0A};
    req_valid = 1'b1; mode_n = 1'b0; req_addr = 32'hC000_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R12 old addr", 64'(rsp_addr), 64'h0000_C000_0000);
    chk("R12 old widget", 64'(rsp_widget), 64'hD);
    @(negedge clk);
    chk("R12 new addr", 64'(rsp_addr), 64'h0001_4000_0000);
    chk("R12 new widget", 64'(rsp_widget), 64'h1);
    req_valid = 1'b0;

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 rerst valid", 64'(rsp_valid), 64'd0);
    chk("R1 rerst addr", 64'(rsp_addr), 64'd0);
    chk("R1 rerst widget", 64'(rsp_widget), 64'd0);
    cfg_idx = 3'd3; #1;
    chk("R1 rerst entry", cfg_rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: zero entry on a nonzero window is a hit, not a miss
    @(negedge clk);
    req_valid = 1'b1; mode_n = 1'b1; req_addr = 32'h3000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 zero entry miss", 64'(rsp_miss), 64'd0);
    chk("R7 zero entry addr", 64'(rsp_addr), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule